// File: doc/BRIEF.md
# Audio RAM Data Port With Format-Selected Access

This block sits in the I/O register space of a DSP core and gives the core direct byte or halfword access to an external audio RAM through one data address. The core first loads a 32-bit current address and a 32-bit end address. Each is written as two 16-bit halves at separate I/O addresses. The core also loads a format code. It then reads or writes the data address.

The format code selects the transfer. Code 0x5 makes a port read fetch one byte and return it zero-extended. Code 0xA makes a port write store the 16-bit value as two bytes, most significant byte first. Any other combination of code and direction moves nothing and sets a sticky error flag.

Every supported transfer advances the current address by the number of bytes it moved. Once the advanced address has gone past the end address, an end flag is raised and the address stays where it is. While the external byte-wide request/acknowledge handshakes are in progress, the core is held through a ready signal.

Top module: `aram_data_port`

## Requirements
- R1: The registers are at these I/O low-byte addresses: current address high half 0xD6, current address low half 0xD7, end address high half 0xD4, end address low half 0xD5, format 0xD1. Each reads back the value last written to it. The transfer address is the high half shifted left by 16, OR'd with the low half.
- R2: A read of address 0xD3 with format 0x5 issues one external read (mem_we=0) at the current address. It returns that byte in bits 7:0 with bits 15:8 zero.
- R3: A write of address 0xD3 with format 0xA issues two external writes. The first carries io_wdata[15:8] at the current address. The second carries io_wdata[7:0] at the current address plus one.
- R4: A port access whose direction does not match the format (a read with any format other than 0x5, or a write with any format other than 0xA) raises no mem_req. It completes with io_ready high in its first cycle, and a read returns 0.
- R5: Such an unsupported access sets bit 1 of the status register at 0xD2. The bit stays set through later accesses until any write to 0xD2 clears it.
- R6: Unless the end flag is already set, a supported read advances the current address by 1 and a supported write advances it by 2.
- R7: The end flag is bit 0 of the status register. It is set when an advanced address is greater than the end address. While it is set, transfers still occur but the current address no longer changes. A write to either current-address half clears it.
- R8: A supported port access holds io_ready low from its first cycle until one cycle after the last external acknowledge. That is W+2 low cycles for a read and 2W+3 for a write, where W is the number of wait cycles per handshake. mem_addr, mem_we and mem_wdata stay stable while mem_req waits for mem_ack.
- R9: After reset every register and both status bits read 0, mem_req is low and io_ready is high.
- R10: A read of any other I/O address returns 0 with io_ready high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| io_addr | input | 8 | I/O address, low byte |
| io_rd | input | 1 | I/O read strobe, held until io_ready |
| io_wr | input | 1 | I/O write strobe, held until io_ready |
| io_wdata | input | 16 | I/O write data |
| io_rdata | output | 16 | I/O read data, valid while io_ready is high |
| io_ready | output | 1 | Access completes in this cycle |
| mem_req | output | 1 | External byte transfer request |
| mem_we | output | 1 | External transfer is a write |
| mem_addr | output | 32 | External byte address |
| mem_wdata | output | 8 | External write byte |
| mem_rdata | input | 8 | External read byte, valid with mem_ack |
| mem_ack | input | 1 | External transfer accepted in this cycle |

## Verification
The assertions check these rules on every cycle:
- io_ready stays low whenever an external request is open.
- A pending request keeps its address, direction and data steady.
- The second byte of a write follows at the next address.
- Port reads never carry upper data bits.
- An unsupported access never raises a request.
- The error flag stays set and the frozen address stays put.

Only the bench's scenarios can show the rest:
- That the right bytes land at the right addresses for every format code in both directions.
- That the stall length scales with the wait cycles.
- That the address steps by 1 or 2.
- That the end flag fires exactly when the address first goes past the end address, and is cleared by reloading the current address.

// File: rtl/aram_port_pkg.sv
package aram_port_pkg;
   typedef enum logic [1:0] {
      XS_IDLE = 2'd0,
      XS_BUSY = 2'd1,
      XS_DONE = 2'd2
   } xfer_state_t;

   localparam int unsigned STAT_END_BIT = 0;
   localparam int unsigned STAT_ERR_BIT = 1;
endpackage

// File: rtl/aram_port_regs.sv
module aram_port_regs #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] wdata,
   input  logic              ld_cur_hi,
   input  logic              ld_cur_lo,
   input  logic              ld_end_hi,
   input  logic              ld_end_lo,
   input  logic              ld_fmt,
   input  logic              clr_err,
   input  logic              err_set,
   input  logic              step_en,
   input  logic              step_two,
   output logic [ADDR_W-1:0] cur_addr,
   output logic [ADDR_W-1:0] end_addr,
   output logic [DATA_W-1:0] fmt,
   output logic              end_flag,
   output logic              err_flag
);
   localparam int unsigned HI_W = ADDR_W - DATA_W;

   logic [ADDR_W:0] next_sum;
   assign next_sum = {1'b0, cur_addr} + (ADDR_W+1)'(step_two ? 2 : 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_addr <= '0;
         end_addr <= '0;
         fmt      <= '0;
         end_flag <= 1'b0;
         err_flag <= 1'b0;
      end else begin
         if (ld_cur_hi) begin
            cur_addr[ADDR_W-1:DATA_W] <= wdata[HI_W-1:0];
            end_flag <= 1'b0;
         end else if (ld_cur_lo) begin
            cur_addr[DATA_W-1:0] <= wdata;
            end_flag <= 1'b0;
         end else if (step_en && !end_flag) begin
            cur_addr <= next_sum[ADDR_W-1:0];
            if (next_sum > {1'b0, end_addr}) end_flag <= 1'b1;
         end
         if (ld_end_hi) end_addr[ADDR_W-1:DATA_W] <= wdata[HI_W-1:0];
         if (ld_end_lo) end_addr[DATA_W-1:0] <= wdata;
         if (ld_fmt) fmt <= wdata;
         if (clr_err) err_flag <= 1'b0;
         else if (err_set) err_flag <= 1'b1;
      end
   end

   // R5: the error flag only falls on an explicit clear
   a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err_flag && !clr_err |=> err_flag);

   // R7: a raised end flag freezes the current address until it is reloaded
   a_r7_end_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      end_flag && !ld_cur_hi && !ld_cur_lo |=> $stable(cur_addr) && end_flag);
endmodule

// File: rtl/aram_port_xfer.sv
module aram_port_xfer
   import aram_port_pkg::*;
#(
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 2 * BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_rd,
   input  logic              start_wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] cur_addr,
   output logic              idle,
   output logic              done,
   output logic [BYTE_W-1:0] rd_byte,
   output logic              step_en,
   output logic              step_two,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [BYTE_W-1:0] mem_wdata,
   input  logic [BYTE_W-1:0] mem_rdata,
   input  logic              mem_ack
);
   xfer_state_t       state;
   logic              idx;
   logic              is_wr;
   logic [DATA_W-1:0] wbuf;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= XS_IDLE;
         idx     <= 1'b0;
         is_wr   <= 1'b0;
         wbuf    <= '0;
         rd_byte <= '0;
      end else begin
         unique case (state)
            XS_IDLE: if (start_rd || start_wr) begin
               state <= XS_BUSY;
               idx   <= 1'b0;
               is_wr <= start_wr;
               wbuf  <= wdata;
            end
            XS_BUSY: if (mem_ack) begin
               if (is_wr && !idx) begin
                  idx <= 1'b1;
               end else begin
                  state <= XS_DONE;
                  if (!is_wr) rd_byte <= mem_rdata;
               end
            end
            XS_DONE: state <= XS_IDLE;
            default: state <= XS_IDLE;
         endcase
      end
   end

   assign idle      = (state == XS_IDLE);
   assign done      = (state == XS_DONE);
   assign step_en   = done;
   assign step_two  = is_wr;
   assign mem_req   = (state == XS_BUSY);
   assign mem_we    = is_wr;
   assign mem_addr  = cur_addr + ADDR_W'(idx);
   assign mem_wdata = idx ? wbuf[BYTE_W-1:0] : wbuf[DATA_W-1:BYTE_W];

   // R8: a pending request keeps its address, direction and data
   a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

   // R3: second byte of a halfword write follows at the next address
   a_r3_pair_next: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we && mem_ack && !idx |=> mem_req && mem_we && (mem_addr == $past(mem_addr) + ADDR_W'(1)));
endmodule

// File: rtl/aram_data_port.sv
module aram_data_port #(
   parameter int unsigned BYTE_W    = 8,
   parameter int unsigned ADDR_W    = 32,
   parameter int unsigned IO_AW     = 8,
   parameter int unsigned A_FMT     = 'hD1,
   parameter int unsigned A_STAT    = 'hD2,
   parameter int unsigned A_PORT    = 'hD3,
   parameter int unsigned A_END_HI  = 'hD4,
   parameter int unsigned A_END_LO  = 'hD5,
   parameter int unsigned A_CUR_HI  = 'hD6,
   parameter int unsigned A_CUR_LO  = 'hD7,
   parameter int unsigned FMT_RD8   = 'h5,
   parameter int unsigned FMT_WR16  = 'hA
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [IO_AW-1:0]       io_addr,
   input  logic                   io_rd,
   input  logic                   io_wr,
   input  logic [2*BYTE_W-1:0]    io_wdata,
   output logic [2*BYTE_W-1:0]    io_rdata,
   output logic                   io_ready,
   output logic                   mem_req,
   output logic                   mem_we,
   output logic [ADDR_W-1:0]      mem_addr,
   output logic [BYTE_W-1:0]      mem_wdata,
   input  logic [BYTE_W-1:0]      mem_rdata,
   input  logic                   mem_ack
);
   import aram_port_pkg::*;

   localparam int unsigned DATA_W = 2 * BYTE_W;

   initial begin
      a_cfg_addr_w: assert (ADDR_W > DATA_W && ADDR_W <= 2 * DATA_W)
         else $error("ADDR_W must lie in (DATA_W, 2*DATA_W]");
      a_cfg_io_w: assert (IO_AW >= 1 && IO_AW <= 16)
         else $error("IO_AW out of range");
   end

   function automatic logic hit(input logic [IO_AW-1:0] a, input int unsigned r);
      return a == IO_AW'(r);
   endfunction

   logic              port_hit, fmt_rd, fmt_wr, rd_ok, wr_ok, bad_acc;
   logic              x_idle, x_done, step_en, step_two;
   logic [BYTE_W-1:0] rd_byte;
   logic [ADDR_W-1:0] cur_addr, end_addr;
   logic [DATA_W-1:0] fmt, cur_hi_rb, end_hi_rb, stat_rb;
   logic              end_flag, err_flag;

   assign port_hit = (io_rd || io_wr) && hit(io_addr, A_PORT);
   assign fmt_rd   = (fmt == DATA_W'(FMT_RD8));
   assign fmt_wr   = (fmt == DATA_W'(FMT_WR16));
   assign rd_ok    = io_rd && !io_wr && fmt_rd;
   assign wr_ok    = io_wr && fmt_wr;
   assign bad_acc  = port_hit && !(rd_ok || wr_ok);

   aram_port_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wdata     (io_wdata),
      .ld_cur_hi (io_wr && hit(io_addr, A_CUR_HI)),
      .ld_cur_lo (io_wr && hit(io_addr, A_CUR_LO)),
      .ld_end_hi (io_wr && hit(io_addr, A_END_HI)),
      .ld_end_lo (io_wr && hit(io_addr, A_END_LO)),
      .ld_fmt    (io_wr && hit(io_addr, A_FMT)),
      .clr_err   (io_wr && hit(io_addr, A_STAT)),
      .err_set   (bad_acc),
      .step_en   (step_en),
      .step_two  (step_two),
      .cur_addr  (cur_addr),
      .end_addr  (end_addr),
      .fmt       (fmt),
      .end_flag  (end_flag),
      .err_flag  (err_flag)
   );

   aram_port_xfer #(.BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_xfer (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_rd  (port_hit && rd_ok && x_idle),
      .start_wr  (port_hit && wr_ok && x_idle),
      .wdata     (io_wdata),
      .cur_addr  (cur_addr),
      .idle      (x_idle),
      .done      (x_done),
      .rd_byte   (rd_byte),
      .step_en   (step_en),
      .step_two  (step_two),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata),
      .mem_ack   (mem_ack)
   );

   generate
      if (ADDR_W == 2 * DATA_W) begin : g_hi_full
         assign cur_hi_rb = cur_addr[ADDR_W-1:DATA_W];
         assign end_hi_rb = end_addr[ADDR_W-1:DATA_W];
      end else begin : g_hi_pad
         assign cur_hi_rb = {{(2*DATA_W-ADDR_W){1'b0}}, cur_addr[ADDR_W-1:DATA_W]};
         assign end_hi_rb = {{(2*DATA_W-ADDR_W){1'b0}}, end_addr[ADDR_W-1:DATA_W]};
      end
   endgenerate

   always_comb begin
      stat_rb = '0;
      stat_rb[STAT_END_BIT] = end_flag;
      stat_rb[STAT_ERR_BIT] = err_flag;
   end

   assign io_ready = !port_hit || bad_acc || x_done;

   always_comb begin
      io_rdata = '0;
      if (io_rd && !io_wr) begin
         if (hit(io_addr, A_PORT))        io_rdata = (x_done && fmt_rd) ? DATA_W'(rd_byte) : '0;
         else if (hit(io_addr, A_CUR_HI)) io_rdata = cur_hi_rb;
         else if (hit(io_addr, A_CUR_LO)) io_rdata = cur_addr[DATA_W-1:0];
         else if (hit(io_addr, A_END_HI)) io_rdata = end_hi_rb;
         else if (hit(io_addr, A_END_LO)) io_rdata = end_addr[DATA_W-1:0];
         else if (hit(io_addr, A_FMT))    io_rdata = fmt;
         else if (hit(io_addr, A_STAT))   io_rdata = stat_rb;
      end
   end

   // R8: the core is stalled whenever an external request is open
   a_r8_stall: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !io_ready);

   // R2: port read data never carries upper bits
   a_r2_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
      io_ready && port_hit && io_rd && !io_wr |-> io_rdata[DATA_W-1:BYTE_W] == '0);

   // R4: an unsupported access never reaches external memory
   a_r4_no_req: assert property (@(posedge clk) disable iff (!rst_n)
      bad_acc |-> !mem_req && io_ready);
endmodule

// File: tb/tb_aram_data_port.sv
module tb_aram_data_port;
   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  io_addr = '0;
   logic        io_rd = 1'b0, io_wr = 1'b0;
   logic [15:0] io_wdata = '0;
   logic [15:0] io_rdata;
   logic        io_ready;
   logic        mem_req, mem_we, mem_ack;
   logic [31:0] mem_addr;
   logic [7:0]  mem_wdata, mem_rdata;

   int n_tests = 0;
   int n_fail  = 0;

   always #(CLK_P/2) clk = ~clk;

   aram_data_port dut (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
      .io_wdata(io_wdata), .io_rdata(io_rdata), .io_ready(io_ready),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack)
   );

   // external memory model with a configurable number of wait cycles
   logic [7:0]  bmem [256];
   int          waits = 0;
   int          wait_cnt = 0;
   int          n_xfer = 0;
   logic [31:0] log_addr [64];
   logic        log_we   [64];
   logic [7:0]  log_data [64];

   initial for (int i = 0; i < 256; i++) bmem[i] = 8'((i * 37 + 11) & 255);

   assign mem_ack   = mem_req && (wait_cnt == waits);
   assign mem_rdata = bmem[mem_addr[7:0]];

   always @(posedge clk) begin
      if (mem_req && !mem_ack) wait_cnt <= wait_cnt + 1;
      else wait_cnt <= 0;
      if (mem_req && mem_ack) begin
         log_addr[n_xfer % 64] <= mem_addr;
         log_we[n_xfer % 64]   <= mem_we;
         log_data[n_xfer % 64] <= mem_we ? mem_wdata : mem_rdata;
         if (mem_we) bmem[mem_addr[7:0]] <= mem_wdata;
         n_xfer <= n_xfer + 1;
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic io_op(input bit wr, input logic [7:0] a, input logic [15:0] d,
                        output logic [15:0] q, output int stall);
      @(negedge clk);
      io_addr = a; io_rd = !wr; io_wr = wr; io_wdata = d;
      stall = 0;
      #1;
      while (!io_ready && stall < 1000) begin
         stall++;
         @(negedge clk); #1;
      end
      q = io_rdata;
      @(posedge clk); #1;
      io_rd = 1'b0; io_wr = 1'b0;
   endtask

   task automatic wr_reg(input logic [7:0] a, input logic [15:0] d);
      logic [15:0] q; int s;
      io_op(1'b1, a, d, q, s);
   endtask

   task automatic rd_reg(input logic [7:0] a, output logic [15:0] q);
      int s;
      io_op(1'b0, a, 16'h0, q, s);
   endtask

   task automatic set_cur(input logic [31:0] v);
      wr_reg(8'hD6, v[31:16]); wr_reg(8'hD7, v[15:0]);
   endtask

   task automatic set_end(input logic [31:0] v);
      wr_reg(8'hD4, v[31:16]); wr_reg(8'hD5, v[15:0]);
   endtask

   task automatic get_cur(output logic [31:0] v);
      logic [15:0] h, l;
      rd_reg(8'hD6, h); rd_reg(8'hD7, l);
      v = {h, l};
   endtask

   initial begin
      #(CLK_P * 150000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      logic [15:0] q;
      logic [31:0] cur, ecur;
      int          s, n0;
      logic [7:0]  eb;

      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R9: reset state
      @(negedge clk);
      check("R9 mem_req", {31'b0, mem_req}, 32'h0);
      check("R9 io_ready", {31'b0, io_ready}, 32'h1);
      foreach (q[i]) ;
      for (int a = 'hD1; a <= 'hD7; a++) begin
         if (a == 'hD3) continue;
         rd_reg(8'(a), q);
         check("R9 register reset", {16'h0, q}, 32'h0);
      end

      // R10: unmapped address
      io_op(1'b0, 8'h40, 16'h0, q, s);
      check("R10 unmapped data", {16'h0, q}, 32'h0);
      check("R10 unmapped stall", s, 0);

      // R1: register load and readback
      wr_reg(8'hD6, 16'h1234); wr_reg(8'hD7, 16'h5678);
      wr_reg(8'hD4, 16'h9ABC); wr_reg(8'hD5, 16'hDEF0);
      wr_reg(8'hD1, 16'h00A5);
      get_cur(cur);
      check("R1 current address", cur, 32'h1234_5678);
      rd_reg(8'hD4, q); check("R1 end high", {16'h0, q}, 32'h9ABC);
      rd_reg(8'hD5, q); check("R1 end low", {16'h0, q}, 32'hDEF0);
      rd_reg(8'hD1, q); check("R1 format", {16'h0, q}, 32'h00A5);

      // R2 R6 R8: byte reads over wait counts
      wr_reg(8'hD1, 16'h0005);
      set_end(32'hFFFF_FFFF);
      ecur = 32'h0002_0010;
      set_cur(ecur);
      for (int w = 0; w < 4; w++) begin
         waits = w;
         for (int k = 0; k < 8; k++) begin
            eb = bmem[ecur[7:0]];
            n0 = n_xfer;
            io_op(1'b0, 8'hD3, 16'h0, q, s);
            check("R2 read data", {16'h0, q}, {24'h0, eb});
            check("R8 read stall", s, w + 2);
            check("R2 one transfer", n_xfer - n0, 1);
            check("R2 read address", log_addr[n0 % 64], ecur);
            check("R2 read direction", {31'b0, log_we[n0 % 64]}, 32'h0);
            ecur = ecur + 1;
         end
      end
      waits = 0;
      get_cur(cur);
      check("R6 advance by one", cur, ecur);

      // R3 R6 R8: halfword writes
      wr_reg(8'hD1, 16'h000A);
      ecur = 32'h0003_0080;
      set_cur(ecur);
      for (int w = 0; w < 3; w++) begin
         waits = w;
         for (int k = 0; k < 4; k++) begin
            logic [15:0] d;
            d = 16'hA5C0 ^ 16'(k * 16'h1357 + w);
            n0 = n_xfer;
            io_op(1'b1, 8'hD3, d, q, s);
            check("R8 write stall", s, 2 * w + 3);
            check("R3 two transfers", n_xfer - n0, 2);
            check("R3 first address", log_addr[n0 % 64], ecur);
            check("R3 first byte high", {24'h0, log_data[n0 % 64]}, {24'h0, d[15:8]});
            check("R3 second address", log_addr[(n0 + 1) % 64], ecur + 1);
            check("R3 second byte low", {24'h0, log_data[(n0 + 1) % 64]}, {24'h0, d[7:0]});
            check("R3 write direction", {30'b0, log_we[n0 % 64], log_we[(n0 + 1) % 64]}, 32'h3);
            check("R3 memory content", {16'h0, bmem[ecur[7:0]], bmem[8'(ecur[7:0] + 1)]}, {16'h0, d});
            ecur = ecur + 2;
         end
      end
      waits = 1;
      get_cur(cur);
      check("R6 advance by two", cur, ecur);

      // R4 R5: every format code in both directions
      ecur = 32'h0000_0040;
      set_cur(ecur);
      for (int f = 0; f < 16; f++) begin
         wr_reg(8'hD1, 16'(f));
         for (int dir = 0; dir < 2; dir++) begin
            bit ok;
            ok = (dir == 0) ? (f == 5) : (f == 10);
            wr_reg(8'hD2, 16'h0);
            eb = bmem[ecur[7:0]];
            n0 = n_xfer;
            io_op(dir[0], 8'hD3, 16'h3C3C, q, s);
            if (ok) begin
               check("R2 format sweep transfer", n_xfer - n0, dir == 0 ? 1 : 2);
               if (dir == 0) check("R2 format sweep data", {16'h0, q}, {24'h0, eb});
               ecur = ecur + (dir == 0 ? 1 : 2);
            end else begin
               check("R4 no transfer", n_xfer - n0, 0);
               check("R4 no stall", s, 0);
               if (dir == 0) check("R4 read returns zero", {16'h0, q}, 32'h0);
            end
            rd_reg(8'hD2, q);
            check(ok ? "R5 no error on supported" : "R5 error set", {16'h0, q}, ok ? 32'h0 : 32'h2);
         end
      end
      get_cur(cur);
      check("R4 address untouched by unsupported", cur, ecur);

      // R5: sticky through a good access, cleared by write
      wr_reg(8'hD1, 16'h0007);
      io_op(1'b0, 8'hD3, 16'h0, q, s);
      wr_reg(8'hD1, 16'h0005);
      io_op(1'b0, 8'hD3, 16'h0, q, s);
      rd_reg(8'hD2, q);
      check("R5 sticky after good read", {16'h0, q}, 32'h2);
      wr_reg(8'hD2, 16'h0000);
      rd_reg(8'hD2, q);
      check("R5 cleared by write", {16'h0, q}, 32'h0);

      // R7: end flag on reads
      waits = 0;
      set_cur(32'h0000_00F0);
      set_end(32'h0000_00F2);
      io_op(1'b0, 8'hD3, 16'h0, q, s);
      io_op(1'b0, 8'hD3, 16'h0, q, s);
      rd_reg(8'hD2, q);
      check("R7 no flag at end address", {16'h0, q}, 32'h0);
      io_op(1'b0, 8'hD3, 16'h0, q, s);
      rd_reg(8'hD2, q);
      check("R7 flag when past end", {16'h0, q}, 32'h1);
      get_cur(cur);
      check("R7 address past end", cur, 32'h0000_00F3);
      n0 = n_xfer;
      eb = bmem[8'hF3];
      io_op(1'b0, 8'hD3, 16'h0, q, s);
      check("R7 transfer while flagged", {16'h0, q}, {24'h0, eb});
      check("R7 flagged transfer address", log_addr[n0 % 64], 32'h0000_00F3);
      get_cur(cur);
      check("R7 address frozen", cur, 32'h0000_00F3);
      wr_reg(8'hD7, 16'h00F0);
      rd_reg(8'hD2, q);
      check("R7 reload clears flag", {16'h0, q}, 32'h0);

      // R7: end flag on writes, high half compared too
      wr_reg(8'hD1, 16'h000A);
      set_end(32'h0000_00F1);
      io_op(1'b1, 8'hD3, 16'h1122, q, s);
      rd_reg(8'hD2, q);
      check("R7 write sets flag", {16'h0, q}, 32'h1);
      io_op(1'b1, 8'hD3, 16'h3344, q, s);
      get_cur(cur);
      check("R7 write address frozen", cur, 32'h0000_00F2);
      wr_reg(8'hD6, 16'h0001);
      rd_reg(8'hD2, q);
      check("R7 high reload clears flag", {16'h0, q}, 32'h0);
      wr_reg(8'hD1, 16'h0005);
      io_op(1'b0, 8'hD3, 16'h0, q, s);
      rd_reg(8'hD2, q);
      check("R7 full-width compare", {16'h0, q}, 32'h1);

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule